// File: doc/BRIEF.md
# Single-Cycle Twenty-Instruction RISC Core

This block is a small 32-bit processor that completes one instruction per clock cycle. It fetches a word from an instruction memory and decodes it. It reads up to two operands from a 32-entry register file and computes a result. It may also touch a data memory. In the same cycle it writes back and picks the next program counter. Register 0 always reads as zero. The core recognises twenty operations spread over three formats: register-register, register-immediate and jump. Every other encoding retires as a no-op.

Both memory ports are word addressed, and both read paths are combinational. The instruction port outputs the program counter divided by four. The data port outputs the effective byte address divided by four, along with the store data and a write strobe that the memory samples on the rising clock edge. There is no branch delay slot: the instruction after a taken branch or jump does not execute.

Top module: `rc20_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, so `imem_addr` reads 0 after that edge, and `dmem_we` stays low while instruction word 0 is not a store.
- R2: The opcode sits in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11 and the function code in 5:0. Every instruction that is not a branch or a jump advances `imem_addr` by exactly one word.
- R3: With opcode 0, these function codes write rd: 32 gives rs+rt, 34 gives rs-rt, 36 gives AND, 37 gives OR, 38 gives XOR and 39 gives NOT(rs OR rt).
- R4: Function code 42 (opcode 0) and opcode 10 write 1 to the destination when rs is less than the second operand as a signed number, and 0 otherwise.
- R5: The immediate is bits 15:0 and the destination is rt. Opcodes 8 (add) and 10 sign-extend it. Opcodes 12 (AND), 13 (OR) and 14 (XOR) zero-extend it.
- R6: Opcode 15 writes the immediate into bits 31:16 of rt and clears bits 15:0.
- R7: Opcodes 35 (load) and 43 (store) use rs plus the sign-extended immediate as the byte address, and `dmem_addr` carries that address divided by four. A store drives rt on `dmem_wdata` with `dmem_we` high. A load writes `dmem_rdata` into rt. No other opcode raises `dmem_we`.
- R8: Opcode 4 branches when rs equals rt, opcode 5 when they differ, and opcode 1 when rs is negative. The target is PC+4 plus the sign-extended immediate shifted left by 2, in either direction. A branch that is not taken falls through to PC+4.
- R9: Opcode 2 jumps to bits 31:28 of PC+4 joined with bits 25:0 of the instruction shifted left by 2.
- R10: Opcode 0 with function code 8 jumps to the byte address held in rs.
- R11: Register 0 reads as zero, and writes to it are discarded.
- R12: Any other opcode, or any other function code under opcode 0, writes no register, raises no store and advances the PC by one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_addr | output | 30 | Word address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 30 | Word address of the load or store |
| dmem_wdata | output | 32 | Store data (rt) |
| dmem_we | output | 1 | Store strobe, sampled by the memory on the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The hardest behaviour to reach from the ports is a control transfer that must not retire a wrong-path instruction, because a skipped instruction leaves no trace unless it would have stored. The stimulus is a program in which every skipped slot after a taken branch, a jump or a register jump holds a store. Any such store would reach the scoreboard as an unexpected item. The program also runs a backward loop whose stored count shows the number of iterations. Register values are invisible at the ports, so each result is carried out through a store and compared with a value derived from the instruction semantics. This covers the discarded writes to register 0 and the unlisted encodings that look like register writes or stores.

// File: rtl/rc20_pkg.sv
package rc20_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int REG_AW    = $clog2(REG_COUNT);
    localparam int WORD_AW   = XLEN - 2;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int IMM_W     = 16;
    localparam int TGT_W     = 26;

    // primary opcodes, bits 31:26
    typedef enum logic [OP_W-1:0] {
        OP_REG  = 6'd0,
        OP_BLTZ = 6'd1,
        OP_J    = 6'd2,
        OP_BEQ  = 6'd4,
        OP_BNE  = 6'd5,
        OP_ADDI = 6'd8,
        OP_SLTI = 6'd10,
        OP_ANDI = 6'd12,
        OP_ORI  = 6'd13,
        OP_XORI = 6'd14,
        OP_LUI  = 6'd15,
        OP_LW   = 6'd35,
        OP_SW   = 6'd43
    } opcode_e;

    // function codes for opcode 0, bits 5:0
    typedef enum logic [FN_W-1:0] {
        FN_JR  = 6'd8,
        FN_ADD = 6'd32,
        FN_SUB = 6'd34,
        FN_AND = 6'd36,
        FN_OR  = 6'd37,
        FN_XOR = 6'd38,
        FN_NOR = 6'd39,
        FN_SLT = 6'd42
    } func_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_HIGH
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE, BR_EQ, BR_NE, BR_NEG
    } branch_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;    // second operand is the extended immediate
        logic    imm_zero;   // zero-extend instead of sign-extend
        logic    reg_write;
        logic    dst_rd;     // destination rd (else rt)
        logic    mem_read;
        logic    mem_write;
        branch_e branch;
        logic    jump;
        logic    jump_reg;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        alu_op: ALU_ADD, use_imm: 1'b0, imm_zero: 1'b0, reg_write: 1'b0,
        dst_rd: 1'b0, mem_read: 1'b0, mem_write: 1'b0, branch: BR_NONE,
        jump: 1'b0, jump_reg: 1'b0
    };

    function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                  input logic zero_ext);
        return zero_ext ? {{(XLEN-IMM_W){1'b0}}, imm}
                        : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic ctrl_t reg_op(input alu_op_e op);
        ctrl_t c;
        c           = CTRL_NOP;
        c.alu_op    = op;
        c.reg_write = 1'b1;
        c.dst_rd    = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t imm_op(input alu_op_e op, input logic zero_ext);
        ctrl_t c;
        c           = CTRL_NOP;
        c.alu_op    = op;
        c.use_imm   = 1'b1;
        c.imm_zero  = zero_ext;
        c.reg_write = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/rc20_decode.sv
module rc20_decode
    import rc20_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [OP_W-1:0] op;
    logic [FN_W-1:0] fn;

    assign op = instr[XLEN-1 -: OP_W];
    assign fn = instr[FN_W-1:0];

    always_comb begin
        ctrl = CTRL_NOP;
        case (op)
            OP_REG: begin
                case (fn)
                    FN_ADD:  ctrl = reg_op(ALU_ADD);
                    FN_SUB:  ctrl = reg_op(ALU_SUB);
                    FN_AND:  ctrl = reg_op(ALU_AND);
                    FN_OR:   ctrl = reg_op(ALU_OR);
                    FN_XOR:  ctrl = reg_op(ALU_XOR);
                    FN_NOR:  ctrl = reg_op(ALU_NOR);
                    FN_SLT:  ctrl = reg_op(ALU_SLT);
                    FN_JR:   ctrl.jump_reg = 1'b1;
                    default: ctrl = CTRL_NOP;
                endcase
            end
            OP_ADDI: ctrl = imm_op(ALU_ADD, 1'b0);
            OP_SLTI: ctrl = imm_op(ALU_SLT, 1'b0);
            OP_ANDI: ctrl = imm_op(ALU_AND, 1'b1);
            OP_ORI:  ctrl = imm_op(ALU_OR, 1'b1);
            OP_XORI: ctrl = imm_op(ALU_XOR, 1'b1);
            OP_LUI:  ctrl = imm_op(ALU_HIGH, 1'b1);
            OP_LW: begin
                ctrl          = imm_op(ALU_ADD, 1'b0);
                ctrl.mem_read = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ:  ctrl.branch = BR_EQ;
            OP_BNE:  ctrl.branch = BR_NE;
            OP_BLTZ: ctrl.branch = BR_NEG;
            OP_J:    ctrl.jump   = 1'b1;
            default: ctrl = CTRL_NOP;
        endcase
    end
endmodule

// File: rtl/rc20_alu.sv
module rc20_alu
    import rc20_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res
);
    always_comb begin
        case (op)
            ALU_ADD:  res = opa + opb;
            ALU_SUB:  res = opa - opb;
            ALU_AND:  res = opa & opb;
            ALU_OR:   res = opa | opb;
            ALU_XOR:  res = opa ^ opb;
            ALU_NOR:  res = ~(opa | opb);
            ALU_SLT:  res = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
            ALU_HIGH: res = {opb[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/rc20_regs.sv
module rc20_regs
    import rc20_pkg::*;
(
    input  logic              clk,
    input  logic [REG_AW-1:0] ra_idx,
    input  logic [REG_AW-1:0] rb_idx,
    output logic [XLEN-1:0]   ra_val,
    output logic [XLEN-1:0]   rb_val,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val
);
    // entry 0 has no storage: it is the constant zero
    logic [XLEN-1:0] store [1:REG_COUNT-1];

    always_ff @(posedge clk) begin
        if (wr_en && wr_idx != '0) begin
            store[wr_idx] <= wr_val;
        end
    end

    assign ra_val = (ra_idx == '0) ? '0 : store[ra_idx];
    assign rb_val = (rb_idx == '0) ? '0 : store[rb_idx];
endmodule

// File: rtl/rc20_core.sv
module rc20_core
    import rc20_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [WORD_AW-1:0] imem_addr,
    input  logic [XLEN-1:0]    imem_rdata,
    output logic [WORD_AW-1:0] dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_we,
    input  logic [XLEN-1:0]    dmem_rdata
);
    logic [WORD_AW-1:0] pc_q, pc_next, pc_seq, pc_branch, pc_jump;
    logic [REG_AW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
    logic [IMM_W-1:0]   imm;
    logic [TGT_W-1:0]   tgt;
    logic [XLEN-1:0]    rs_val, rt_val, imm_ext, alu_b, alu_res, wb_val;
    logic               taken;
    ctrl_t              ctrl;

    assign rs_idx = imem_rdata[25:21];
    assign rt_idx = imem_rdata[20:16];
    assign rd_idx = imem_rdata[15:11];
    assign imm    = imem_rdata[IMM_W-1:0];
    assign tgt    = imem_rdata[TGT_W-1:0];

    rc20_decode u_decode (.instr(imem_rdata), .ctrl(ctrl));

    rc20_regs u_regs (
        .clk    (clk),
        .ra_idx (rs_idx),
        .rb_idx (rt_idx),
        .ra_val (rs_val),
        .rb_val (rt_val),
        .wr_en  (ctrl.reg_write),
        .wr_idx (wr_idx),
        .wr_val (wb_val)
    );

    assign imm_ext = extend_imm(imm, ctrl.imm_zero);
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    rc20_alu u_alu (.opa(rs_val), .opb(alu_b), .op(ctrl.alu_op), .res(alu_res));

    assign wr_idx = ctrl.dst_rd ? rd_idx : rt_idx;
    assign wb_val = ctrl.mem_read ? dmem_rdata : alu_res;

    assign dmem_addr  = alu_res[XLEN-1:2];
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_write;

    // next-PC selection, all in the word domain
    assign pc_seq    = pc_q + 1'b1;
    assign pc_branch = pc_seq + {{(WORD_AW-IMM_W){imm[IMM_W-1]}}, imm};
    assign pc_jump   = {pc_seq[WORD_AW-1:TGT_W], tgt};

    always_comb begin
        case (ctrl.branch)
            BR_EQ:   taken = (rs_val == rt_val);
            BR_NE:   taken = (rs_val != rt_val);
            BR_NEG:  taken = rs_val[XLEN-1];
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        if (ctrl.jump_reg)  pc_next = rs_val[XLEN-1:2];
        else if (ctrl.jump) pc_next = pc_jump;
        else if (taken)     pc_next = pc_branch;
        else                pc_next = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign imem_addr = pc_q;
endmodule

// File: rtl/rc20_checks.sv
module rc20_checks
    import rc20_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [WORD_AW-1:0] imem_addr,
    input logic [XLEN-1:0]    imem_rdata,
    input logic               dmem_we,
    input logic [XLEN-1:0]    rs_val
);
    logic [OP_W-1:0]    op;
    logic [FN_W-1:0]    fn;
    logic               is_jr, is_jump, is_branch;
    logic [WORD_AW-1:0] addr_plus1;
    logic               rst_q;

    assign op         = imem_rdata[XLEN-1 -: OP_W];
    assign fn         = imem_rdata[FN_W-1:0];
    assign is_jr      = (op == OP_REG) && (fn == FN_JR);
    assign is_jump    = (op == OP_J);
    assign is_branch  = (op == OP_BEQ) || (op == OP_BNE) || (op == OP_BLTZ);
    assign addr_plus1 = imem_addr + 1'b1;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_pc_R1: assert (imem_addr == '0)
                else $error("pc not cleared by reset");
        end
    end

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        !(is_jr || is_jump || is_branch) |=> imem_addr == $past(addr_plus1));

    assert_store_gate_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> op == OP_SW);

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> imem_addr == {$past(addr_plus1[WORD_AW-1:TGT_W]),
                                  $past(imem_rdata[TGT_W-1:0])});

    assert_reg_jump_R10: assert property (@(posedge clk) disable iff (rst)
        is_jr |=> imem_addr == $past(rs_val[XLEN-1:2]));

    assert_zero_reg_R11: assert property (@(posedge clk) disable iff (rst)
        imem_rdata[25:21] == '0 |-> rs_val == '0);
endmodule

bind rc20_core rc20_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .rs_val     (rs_val)
);

// File: tb/rc20_core_bench.sv
module rc20_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [29:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] rom [0:63];
    logic [31:0] ram [0:31];

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [29:0] addr;
        logic [31:0] data;
        string       tag;
    } store_item_t;
    store_item_t expq[$];

    always #5 clk = ~clk;

    rc20_core u_rc20_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = rom[imem_addr[5:0]];
    assign dmem_rdata = ram[dmem_addr[4:0]];

    always @(posedge clk) if (dmem_we === 1'b1) ram[dmem_addr[4:0]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs,
                                          logic [4:0] rt, logic [4:0] rd);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'd2, t};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver side: queue an expected store
    task automatic expect_store(input int byte_addr, input logic [31:0] data,
                                input string tag);
        store_item_t it;
        it.addr = 30'(byte_addr / 4);
        it.data = data;
        it.tag  = tag;
        expq.push_back(it);
    endtask

    // monitor side: every store retired is popped and compared
    always @(negedge clk) begin
        if (!rst && dmem_we === 1'b1) begin
            if (expq.size() == 0) begin
                check(1'b0, "R12 unexpected store", {2'b0, dmem_addr}, 32'hx);
            end else begin
                store_item_t it;
                it = expq.pop_front();
                check(dmem_addr == it.addr, {it.tag, " addr"}, {2'b0, dmem_addr}, {2'b0, it.addr});
                check(dmem_wdata == it.data, {it.tag, " data"}, dmem_wdata, it.data);
            end
        end
    end

    task automatic load_program();
        for (int i = 0; i < 64; i++) rom[i] = 32'h0;     // fn 0: unlisted, no-op
        for (int i = 0; i < 32; i++) ram[i] = 32'h0;
        rom[0]  = enc_i(6'd15, 5'd0, 5'd1, 16'h1234);    // lui r1
        rom[1]  = enc_i(6'd13, 5'd1, 5'd1, 16'h8765);    // ori r1
        rom[2]  = enc_i(6'd43, 5'd0, 5'd1, 16'd0);
        rom[3]  = enc_i(6'd8,  5'd0, 5'd2, 16'hFFFD);    // addi r2 = -3
        rom[4]  = enc_i(6'd43, 5'd0, 5'd2, 16'd4);
        rom[5]  = enc_i(6'd12, 5'd2, 5'd3, 16'hF0F0);    // andi
        rom[6]  = enc_i(6'd43, 5'd0, 5'd3, 16'd8);
        rom[7]  = enc_i(6'd14, 5'd1, 5'd4, 16'hFFFF);    // xori
        rom[8]  = enc_i(6'd43, 5'd0, 5'd4, 16'd12);
        rom[9]  = enc_r(6'd32, 5'd1, 5'd2, 5'd5);        // add
        rom[10] = enc_r(6'd34, 5'd1, 5'd2, 5'd6);        // sub
        rom[11] = enc_i(6'd43, 5'd0, 5'd5, 16'd16);
        rom[12] = enc_i(6'd43, 5'd0, 5'd6, 16'd20);
        rom[13] = enc_r(6'd38, 5'd1, 5'd2, 5'd7);        // xor
        rom[14] = enc_r(6'd39, 5'd1, 5'd3, 5'd8);        // nor
        rom[15] = enc_r(6'd36, 5'd1, 5'd3, 5'd9);        // and
        rom[16] = enc_r(6'd37, 5'd1, 5'd3, 5'd10);       // or
        rom[17] = enc_i(6'd43, 5'd0, 5'd7, 16'd24);
        rom[18] = enc_i(6'd43, 5'd0, 5'd8, 16'd28);
        rom[19] = enc_i(6'd43, 5'd0, 5'd9, 16'd32);
        rom[20] = enc_i(6'd43, 5'd0, 5'd10, 16'd36);
        rom[21] = enc_r(6'd42, 5'd2, 5'd1, 5'd11);       // slt -3 < pos
        rom[22] = enc_r(6'd42, 5'd1, 5'd2, 5'd12);       // slt pos < -3
        rom[23] = enc_i(6'd10, 5'd2, 5'd13, 16'hFFFE);   // slti -3 < -2
        rom[24] = enc_i(6'd43, 5'd0, 5'd11, 16'd40);
        rom[25] = enc_i(6'd43, 5'd0, 5'd12, 16'd44);
        rom[26] = enc_i(6'd43, 5'd0, 5'd13, 16'd48);
        rom[27] = enc_i(6'd8,  5'd0, 5'd0, 16'd5);       // write to r0
        rom[28] = enc_i(6'd43, 5'd0, 5'd0, 16'd52);
        rom[29] = enc_i(6'd8,  5'd0, 5'd22, 16'd12);
        rom[30] = enc_i(6'd35, 5'd22, 5'd14, 16'hFFF8);  // lw -8(r22) -> byte 4
        rom[31] = enc_i(6'd8,  5'd14, 5'd15, 16'd16);
        rom[32] = enc_i(6'd43, 5'd22, 5'd15, 16'd44);    // byte 56
        rom[33] = enc_i(6'd4,  5'd1, 5'd1, 16'd1);       // beq taken
        rom[34] = enc_i(6'd43, 5'd0, 5'd1, 16'd60);      // wrong path
        rom[35] = enc_i(6'd5,  5'd1, 5'd1, 16'd1);       // bne not taken
        rom[36] = enc_i(6'd8,  5'd0, 5'd16, 16'd7);
        rom[37] = enc_i(6'd43, 5'd0, 5'd16, 16'd60);
        rom[38] = enc_i(6'd1,  5'd2, 5'd0, 16'd1);       // bltz taken
        rom[39] = enc_i(6'd43, 5'd0, 5'd0, 16'd64);      // wrong path
        rom[40] = enc_i(6'd1,  5'd1, 5'd0, 16'd1);       // bltz not taken
        rom[41] = enc_i(6'd8,  5'd0, 5'd17, 16'd9);
        rom[42] = enc_i(6'd43, 5'd0, 5'd17, 16'd64);
        rom[43] = enc_j(26'd46);
        rom[44] = enc_i(6'd43, 5'd0, 5'd0, 16'd68);      // wrong path
        rom[45] = enc_i(6'd43, 5'd0, 5'd0, 16'd68);      // wrong path
        rom[46] = enc_i(6'd8,  5'd0, 5'd18, 16'd204);    // byte address of word 51
        rom[47] = enc_r(6'd8,  5'd18, 5'd0, 5'd0);       // jr
        rom[48] = enc_i(6'd43, 5'd0, 5'd0, 16'd68);      // wrong path
        rom[49] = enc_i(6'd43, 5'd0, 5'd0, 16'd68);
        rom[50] = enc_i(6'd43, 5'd0, 5'd0, 16'd68);
        rom[51] = enc_i(6'd8,  5'd0, 5'd19, 16'h0055);
        rom[52] = enc_i(6'd43, 5'd0, 5'd19, 16'd68);
        rom[53] = enc_i(6'd8,  5'd0, 5'd20, 16'd3);
        rom[54] = enc_r(6'd32, 5'd0, 5'd0, 5'd21);
        rom[55] = enc_i(6'd8,  5'd21, 5'd21, 16'd5);
        rom[56] = enc_i(6'd8,  5'd20, 5'd20, 16'hFFFF);
        rom[57] = enc_i(6'd5,  5'd20, 5'd0, 16'hFFFD);   // backward to 55
        rom[58] = enc_i(6'd43, 5'd0, 5'd21, 16'd72);
        rom[59] = enc_i(6'd63, 5'd0, 5'd1, 16'hFFFF);    // unlisted opcode
        rom[60] = enc_r(6'd1,  5'd0, 5'd0, 5'd1);        // unlisted fn, rd=r1
        rom[61] = enc_i(6'd41, 5'd0, 5'd1, 16'd80);      // unlisted store-like
        rom[62] = enc_i(6'd43, 5'd0, 5'd1, 16'd76);
        rom[63] = enc_j(26'd63);                         // halt
    endtask

    task automatic expect_all();
        logic [31:0] a, b, c;
        a = {16'h1234, 16'h0000} | 32'h0000_8765;
        b = 32'hFFFF_FFFD;
        c = 32'h0000_F0F0;
        expect_store(0,  a, "R6 lui/ori");
        expect_store(4,  b, "R5 addi sign");
        expect_store(8,  b & c, "R5 andi zero");
        expect_store(12, a ^ 32'h0000_FFFF, "R5 xori zero");
        expect_store(16, a + b, "R3 add");
        expect_store(20, a - b, "R3 sub");
        expect_store(24, a ^ b, "R3 xor");
        expect_store(28, ~(a | c), "R3 nor");
        expect_store(32, a & c, "R3 and");
        expect_store(36, a | c, "R3 or");
        expect_store(40, 32'd1, "R4 slt true");
        expect_store(44, 32'd0, "R4 slt false");
        expect_store(48, 32'd1, "R4 slti");
        expect_store(52, 32'd0, "R11 r0 write");
        expect_store(56, b + 32'd16, "R7 lw negative offset");
        expect_store(60, 32'd7, "R8 beq/bne");
        expect_store(64, 32'd9, "R8 bltz");
        expect_store(68, 32'h55, "R9 R10 jumps");
        expect_store(72, 32'd15, "R8 backward loop");
        expect_store(76, a, "R12 unlisted no-op");
    endtask

    initial begin
        load_program();
        expect_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 30'd0, "R1 reset pc", {2'b0, imem_addr}, 32'd0);
        check(dmem_we == 1'b0, "R1 no store in reset", {31'b0, dmem_we}, 32'd0);
        rst = 1'b0;
        for (int n = 0; n < 2000 && expq.size() != 0; n++) @(negedge clk);
        check(expq.size() == 0, "R7 stores outstanding", expq.size(), 32'd0);
        repeat (4) @(negedge clk);
        check(imem_addr == 30'd63, "R9 halt self-jump", {2'b0, imem_addr}, 32'd63);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0 pending stores", expq.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule